// File: doc/BRIEF.md
# CPU Interrupt Entry Controller

This block sits next to a 32-bit processor core and decides when the core must leave its instruction stream for a reset, a non-maskable interrupt (NMI) or one of six maskable interrupt lines. When it takes an event it produces the address the core jumps to and updates the processor status word (PSW). It also writes the exception cause register and saves the interrupted program counter and PSW into a shadow pair. NMIs use one shadow pair and maskable events use another, so a maskable handler's saved state survives an NMI.

The block owns the PSW. The core reads it from the `psw` output, writes it through `psw_we`/`psw_wdata`, and gives the current program counter on `cur_pc`. The core raises `accept` in cycles where an entry may start, and pulses `nmi_ret` when it returns from an NMI handler. The block produces at most one entry per cycle. An entry shows as a one-cycle `take` pulse with the target on `take_pc`. If an NMI arrives while an NMI handler is already running, the block keeps it in a single pending flag and enters it after that handler returns.

Top module: `irq_entry_ctrl`

## Requirements
- R1: A reset request (`rst_req` high) gives, after the next clock edge, `take`=1, `take_pc`=0, `psw`=0x20, `ecr`=0 and a cleared pending flag. The synchronous `rst_n` reset leaves `psw`=0x20, `ecr`=0, `take`=0 and `nmi_pend`=0.
- R2: Every NMI or maskable entry sets PSW bit 5 (interrupt disable) and clears PSW bit 6 (exception marker) in the new `psw`.
- R3: An NMI request with `accept` high and PSW bit 7 (NMI active) clear is taken. It gives `take_pc`=0x10 and `fepc`=`cur_pc`. `fepsw` gets the PSW from before the entry and PSW bit 7 is set. `ecr[31:16]` becomes 0x0010 and `ecr[15:0]` is unchanged.
- R4: An NMI request that arrives while PSW bit 7 is set (or while `accept` is low) is not taken and sets `nmi_pend`. Further requests in that state are merged, so only one re-entry follows.
- R5: A maskable entry gives `eipc`=`cur_pc`. `eipsw` gets the PSW from before the entry. `ecr[15:0]` takes the source's vector and `ecr[31:16]` is unchanged.
- R6: Source i (bit i of `mi_req`) has vector 0x80 + 0x10·i, which is also `take_pc`. When several sources request at once, the lowest i wins.
- R7: Maskable requests produce no entry while PSW bit 5 or bit 7 is set, or while `accept` is low. In that case `eipc`/`eipsw` keep their values.
- R8: Priority is reset request over NMI (new or pending) over maskable. The losing request leaves its shadow pair untouched.
- R9: `nmi_ret` clears PSW bit 7 at the next edge. If `nmi_pend` is set, the NMI is entered on the following edge (given `accept`) and `nmi_pend` clears.
- R10: `psw_we` loads `psw_wdata` into the PSW at the next edge. An entry taken in the same cycle overrides the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_req | input | 1 | Reset event request |
| nmi_req | input | 1 | NMI event pulse |
| mi_req | input | 6 | Maskable request levels, bit i = source i |
| accept | input | 1 | Core can start an entry this cycle |
| nmi_ret | input | 1 | Core returns from NMI handler |
| cur_pc | input | 32 | Program counter to save on entry |
| psw_we | input | 1 | Core PSW write enable |
| psw_wdata | input | 32 | Core PSW write data |
| take | output | 1 | One-cycle entry pulse |
| take_pc | output | 32 | Entry target address |
| psw | output | 32 | Current PSW |
| ecr | output | 32 | Cause register, [31:16] NMI code, [15:0] maskable code |
| fepc | output | 32 | Saved PC for NMI |
| fepsw | output | 32 | Saved PSW for NMI |
| eipc | output | 32 | Saved PC for maskable event |
| eipsw | output | 32 | Saved PSW for maskable event |
| nmi_pend | output | 1 | Blocked NMI waiting |

## Verification
Each entry, PSW write, pending-flag change and shadow-register load is registered, so it shows one clock edge after the cycle in which the stimulus was presented. The one exception is a pending NMI released by `nmi_ret`: the PSW clears one edge after the strobe and the re-entry appears one edge after that. The bench applies inputs just after an edge and samples just after the next edge, checking every result at the cycle where it is due. For the re-entry it checks both the intermediate cycle (no `take`, bit 7 clear) and the entry cycle.

// File: rtl/irq_entry_pkg.sv
// Package: shared types for the interrupt entry controller.
// Assumes: nothing beyond IEEE 1800-2017.
package irq_entry_pkg;

    // Kind of entry selected in the current cycle.
    typedef enum logic [1:0] {
        ENT_NONE  = 2'd0,
        ENT_RESET = 2'd1,
        ENT_NMI   = 2'd2,
        ENT_MASK  = 2'd3
    } entry_e;

endpackage

// File: rtl/irq_mask_sel.sv
// Module: irq_mask_sel
// Picks the lowest-numbered active maskable source and computes its vector
// as VEC_BASE + index * VEC_STEP.
// Assumes: 'enable' already folds in masking and higher-priority events.
module irq_mask_sel #(
    parameter int              N        = 6,
    parameter int              AW       = 32,
    parameter logic [AW-1:0]   VEC_BASE = 'h80,
    parameter logic [AW-1:0]   VEC_STEP = 'h10
) (
    input  logic [N-1:0]  req,
    input  logic          enable,
    output logic          hit,
    output logic [AW-1:0] vec
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [N:0]   seen;
    logic [N-1:0] grant;
    logic [IW-1:0] idx;

    assign seen[0] = 1'b0;

    // Prefix chain: a source is granted only if no lower source requests.
    for (genvar g = 0; g < N; g++) begin : g_chain
        assign seen[g+1] = seen[g] | req[g];
        assign grant[g]  = req[g] & ~seen[g];
    end

    // Encode the one-hot grant into an index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = idx | IW'(i);
        end
    end

    assign hit = enable & seen[N];
    assign vec = VEC_BASE + (AW'(idx) * VEC_STEP);

endmodule

// File: rtl/irq_nmi_gate.sv
// Module: irq_nmi_gate
// Decides whether an NMI (new or pending) enters this cycle and keeps the
// single, non-counting pending flag.
// Assumes: nmi_req is an event pulse; np_now is the PSW NMI-active bit.
module irq_nmi_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_req,
    input  logic nmi_req,
    input  logic accept,
    input  logic np_now,
    output logic go,
    output logic pend
);
    logic pend_q;
    logic pend_d;

    assign go   = ~rst_req & accept & ~np_now & (nmi_req | pend_q);
    assign pend = pend_q;

    // Next pending state: cleared by reset or entry, set by a blocked request.
    always_comb begin
        pend_d = pend_q;
        if (rst_req)      pend_d = 1'b0;
        else if (go)      pend_d = 1'b0;
        else if (nmi_req) pend_d = 1'b1;
    end

    // Pending flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

endmodule

// File: rtl/irq_shadow_pair.sv
// Module: irq_shadow_pair
// Holds one saved PC/PSW pair, loaded on the entry that owns it.
// Assumes: load is a single-cycle strobe from the entry decision.
module irq_shadow_pair #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [XLEN-1:0] pc_in,
    input  logic [XLEN-1:0] psw_in,
    output logic [XLEN-1:0] pc_q,
    output logic [XLEN-1:0] psw_q
);
    // Capture the interrupted context on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            psw_q <= '0;
        end else if (load) begin
            pc_q  <= pc_in;
            psw_q <= psw_in;
        end
    end

endmodule

// File: rtl/irq_entry_ctrl.sv
// Module: irq_entry_ctrl
// Interrupt entry controller: arbitrates reset, NMI and maskable requests,
// owns the PSW and cause register, and loads the NMI or maskable shadow pair.
// Assumes: the core jumps to take_pc when take is high and reads psw from
// this block; maskable requests are levels held by their sources.
module irq_entry_ctrl
    import irq_entry_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              N_MI     = 6,
    parameter int              ID_BIT   = 5,
    parameter int              EP_BIT   = 6,
    parameter int              NP_BIT   = 7,
    parameter logic [XLEN-1:0] RST_PC   = '0,
    parameter logic [XLEN-1:0] RST_PSW  = 'h20,
    parameter logic [XLEN-1:0] NMI_VEC  = 'h10,
    parameter int              NMI_CODE = 'h10,
    parameter logic [XLEN-1:0] VEC_BASE = 'h80,
    parameter logic [XLEN-1:0] VEC_STEP = 'h10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rst_req,
    input  logic            nmi_req,
    input  logic [N_MI-1:0] mi_req,
    input  logic            accept,
    input  logic            nmi_ret,
    input  logic [XLEN-1:0] cur_pc,
    input  logic            psw_we,
    input  logic [XLEN-1:0] psw_wdata,
    output logic            take,
    output logic [XLEN-1:0] take_pc,
    output logic [XLEN-1:0] psw,
    output logic [XLEN-1:0] ecr,
    output logic [XLEN-1:0] fepc,
    output logic [XLEN-1:0] fepsw,
    output logic [XLEN-1:0] eipc,
    output logic [XLEN-1:0] eipsw,
    output logic            nmi_pend
);
    localparam int CW = XLEN / 2;
    localparam logic [XLEN-1:0] ONE  = {{(XLEN-1){1'b0}}, 1'b1};
    localparam logic [XLEN-1:0] ID_M = ONE << ID_BIT;
    localparam logic [XLEN-1:0] EP_M = ONE << EP_BIT;
    localparam logic [XLEN-1:0] NP_M = ONE << NP_BIT;

    logic [XLEN-1:0] psw_q, psw_d;
    logic [XLEN-1:0] ecr_q, ecr_d;
    logic            take_q;
    logic [XLEN-1:0] take_pc_q, take_pc_d;
    logic            nmi_go;
    logic            mi_en, mi_hit;
    logic [XLEN-1:0] mi_vec;
    logic [XLEN-1:0] psw_entry;
    entry_e          kind;

    // NMI decision and pending flag.
    irq_nmi_gate u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_req (rst_req),
        .nmi_req (nmi_req),
        .accept  (accept),
        .np_now  (psw_q[NP_BIT]),
        .go      (nmi_go),
        .pend    (nmi_pend)
    );

    assign mi_en = accept & ~psw_q[ID_BIT] & ~psw_q[NP_BIT] & ~rst_req & ~nmi_go;

    // Maskable source selection.
    irq_mask_sel #(
        .N        (N_MI),
        .AW       (XLEN),
        .VEC_BASE (VEC_BASE),
        .VEC_STEP (VEC_STEP)
    ) u_sel (
        .req    (mi_req),
        .enable (mi_en),
        .hit    (mi_hit),
        .vec    (mi_vec)
    );

    // Entry kind by fixed priority: reset, NMI, maskable.
    always_comb begin
        if (rst_req)     kind = ENT_RESET;
        else if (nmi_go) kind = ENT_NMI;
        else if (mi_hit) kind = ENT_MASK;
        else             kind = ENT_NONE;
    end

    assign psw_entry = (psw_q | ID_M) & ~EP_M;

    // Next PSW, cause register and target for the selected entry.
    always_comb begin
        psw_d     = psw_q;
        ecr_d     = ecr_q;
        take_pc_d = take_pc_q;
        unique case (kind)
            ENT_RESET: begin
                psw_d     = RST_PSW;
                ecr_d     = '0;
                take_pc_d = RST_PC;
            end
            ENT_NMI: begin
                psw_d            = psw_entry | NP_M;
                ecr_d[XLEN-1:CW] = CW'(NMI_CODE);
                take_pc_d        = NMI_VEC;
            end
            ENT_MASK: begin
                psw_d          = psw_entry;
                ecr_d[CW-1:0]  = mi_vec[CW-1:0];
                take_pc_d      = mi_vec;
            end
            default: begin
                if (psw_we)  psw_d = psw_wdata;
                if (nmi_ret) psw_d = psw_d & ~NP_M;
            end
        endcase
    end

    // Architectural state and entry pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psw_q     <= RST_PSW;
            ecr_q     <= '0;
            take_q    <= 1'b0;
            take_pc_q <= RST_PC;
        end else begin
            psw_q     <= psw_d;
            ecr_q     <= ecr_d;
            take_q    <= (kind != ENT_NONE);
            take_pc_q <= take_pc_d;
        end
    end

    // NMI shadow pair.
    irq_shadow_pair #(.XLEN(XLEN)) u_fe (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (kind == ENT_NMI),
        .pc_in  (cur_pc),
        .psw_in (psw_q),
        .pc_q   (fepc),
        .psw_q  (fepsw)
    );

    // Maskable shadow pair.
    irq_shadow_pair #(.XLEN(XLEN)) u_ei (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (kind == ENT_MASK),
        .pc_in  (cur_pc),
        .psw_in (psw_q),
        .pc_q   (eipc),
        .psw_q  (eipsw)
    );

    assign take    = take_q;
    assign take_pc = take_pc_q;
    assign psw     = psw_q;
    assign ecr     = ecr_q;

endmodule

// File: rtl/irq_entry_ctrl_chk.sv
// Module: irq_entry_ctrl_chk
// Checker with temporal properties on the entry controller's ports.
// Assumes: bound to every irq_entry_ctrl instance below.
module irq_entry_ctrl_chk #(
    parameter int              XLEN     = 32,
    parameter int              N_MI     = 6,
    parameter int              ID_BIT   = 5,
    parameter int              EP_BIT   = 6,
    parameter int              NP_BIT   = 7,
    parameter logic [XLEN-1:0] RST_PC   = '0,
    parameter logic [XLEN-1:0] RST_PSW  = 'h20,
    parameter logic [XLEN-1:0] NMI_VEC  = 'h10,
    parameter int              NMI_CODE = 'h10,
    parameter logic [XLEN-1:0] VEC_BASE = 'h80
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rst_req,
    input logic            nmi_req,
    input logic [N_MI-1:0] mi_req,
    input logic            nmi_ret,
    input logic [XLEN-1:0] cur_pc,
    input logic            take,
    input logic [XLEN-1:0] take_pc,
    input logic [XLEN-1:0] psw,
    input logic [XLEN-1:0] ecr,
    input logic [XLEN-1:0] fepc,
    input logic [XLEN-1:0] fepsw,
    input logic [XLEN-1:0] eipc,
    input logic            nmi_pend
);
    localparam int CW = XLEN / 2;

    a_r1_reset_req: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (take && take_pc == RST_PC && psw == RST_PSW && ecr == '0 && !nmi_pend));

    a_r2_entry_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_pc != RST_PC) |-> (psw[ID_BIT] && !psw[EP_BIT]));

    a_r3_nmi_save: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_pc == NMI_VEC) |->
            (psw[NP_BIT] && ecr[XLEN-1:CW] == CW'(NMI_CODE) &&
             fepc == $past(cur_pc) && fepsw == $past(psw)));

    a_r4_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && psw[NP_BIT] && !rst_req) |=> (nmi_pend && !take));

    a_r5_mask_save: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_pc >= VEC_BASE) |->
            (ecr[CW-1:0] == take_pc[CW-1:0] &&
             ecr[XLEN-1:CW] == $past(ecr[XLEN-1:CW]) && eipc == $past(cur_pc)));

    a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
        ((psw[ID_BIT] || psw[NP_BIT]) && !rst_req && !nmi_req && !nmi_pend) |=> !take);

    a_r9_ret_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_ret && psw[NP_BIT] && !rst_req) |=> !psw[NP_BIT]);

endmodule

bind irq_entry_ctrl irq_entry_ctrl_chk #(
    .XLEN     (XLEN),
    .N_MI     (N_MI),
    .ID_BIT   (ID_BIT),
    .EP_BIT   (EP_BIT),
    .NP_BIT   (NP_BIT),
    .RST_PC   (RST_PC),
    .RST_PSW  (RST_PSW),
    .NMI_VEC  (NMI_VEC),
    .NMI_CODE (NMI_CODE),
    .VEC_BASE (VEC_BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_req  (rst_req),
    .nmi_req  (nmi_req),
    .mi_req   (mi_req),
    .nmi_ret  (nmi_ret),
    .cur_pc   (cur_pc),
    .take     (take),
    .take_pc  (take_pc),
    .psw      (psw),
    .ecr      (ecr),
    .fepc     (fepc),
    .fepsw    (fepsw),
    .eipc     (eipc),
    .nmi_pend (nmi_pend)
);

// File: tb/irq_entry_ctrl_bench.sv
// Directed bench for irq_entry_ctrl: one task per scenario.
module irq_entry_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rst_req, nmi_req, accept, nmi_ret, psw_we;
    logic [5:0]  mi_req;
    logic [31:0] cur_pc, psw_wdata;
    logic        take, nmi_pend;
    logic [31:0] take_pc, psw, ecr, fepc, fepsw, eipc, eipsw;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_entry_ctrl u_irq_entry_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_req   (rst_req),
        .nmi_req   (nmi_req),
        .mi_req    (mi_req),
        .accept    (accept),
        .nmi_ret   (nmi_ret),
        .cur_pc    (cur_pc),
        .psw_we    (psw_we),
        .psw_wdata (psw_wdata),
        .take      (take),
        .take_pc   (take_pc),
        .psw       (psw),
        .ecr       (ecr),
        .fepc      (fepc),
        .fepsw     (fepsw),
        .eipc      (eipc),
        .eipsw     (eipsw),
        .nmi_pend  (nmi_pend)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    // Advance one edge and settle just after it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        rst_req = 0; nmi_req = 0; nmi_ret = 0; psw_we = 0; mi_req = '0;
    endtask

    task automatic write_psw(input logic [31:0] v);
        idle();
        psw_we = 1; psw_wdata = v;
        tick();
        idle();
    endtask

    task automatic t_reset_state();
        chk("R1", "take after rst_n", {31'b0, take}, 32'h0);
        chk("R1", "psw after rst_n", psw, 32'h20);
        chk("R1", "ecr after rst_n", ecr, 32'h0);
        chk("R1", "pend after rst_n", {31'b0, nmi_pend}, 32'h0);
    endtask

    task automatic t_psw_write();
        write_psw(32'h40);
        chk("R10", "psw write", psw, 32'h40);
    endtask

    task automatic t_nmi_entry();
        idle();
        cur_pc = 32'h2000; nmi_req = 1;
        tick();
        idle();
        chk("R3", "take", {31'b0, take}, 32'h1);
        chk("R3", "take_pc", take_pc, 32'h10);
        chk("R3", "fepc", fepc, 32'h2000);
        chk("R3", "fepsw", fepsw, 32'h40);
        chk("R2", "psw after nmi", psw, 32'hA0);
        chk("R3", "ecr", ecr, 32'h0010_0000);
        tick();
        chk("R3", "take pulse ends", {31'b0, take}, 32'h0);
    endtask

    task automatic t_nmi_pending();
        idle();
        cur_pc = 32'h2100; nmi_req = 1;
        tick();
        chk("R4", "blocked nmi no take", {31'b0, take}, 32'h0);
        chk("R4", "pend set", {31'b0, nmi_pend}, 32'h1);
        tick();
        idle();
        chk("R4", "fepc kept", fepc, 32'h2000);
        tick();
        chk("R4", "no entry while active", {31'b0, take}, 32'h0);
        nmi_ret = 1; cur_pc = 32'h3000;
        tick();
        idle();
        cur_pc = 32'h3004;
        chk("R9", "np cleared", psw, 32'h20);
        chk("R9", "no take on ret edge", {31'b0, take}, 32'h0);
        chk("R9", "pend held", {31'b0, nmi_pend}, 32'h1);
        tick();
        chk("R9", "re-entry take", {31'b0, take}, 32'h1);
        chk("R9", "re-entry pc", take_pc, 32'h10);
        chk("R9", "re-entry fepc", fepc, 32'h3004);
        chk("R9", "re-entry fepsw", fepsw, 32'h20);
        chk("R9", "pend cleared", {31'b0, nmi_pend}, 32'h0);
        tick();
        chk("R4", "only one re-entry", {31'b0, take}, 32'h0);
    endtask

    task automatic t_mask_each();
        for (int i = 0; i < 6; i++) begin
            write_psw(32'h40);
            cur_pc = 32'h4000 + 32'(4 * i); mi_req = 6'(1 << i);
            tick();
            idle();
            chk("R6", "vector", take_pc, 32'h80 + 32'(16 * i));
            chk("R5", "take", {31'b0, take}, 32'h1);
            chk("R5", "ecr", ecr, 32'h0010_0000 | (32'h80 + 32'(16 * i)));
            chk("R5", "eipc", eipc, 32'h4000 + 32'(4 * i));
            chk("R5", "eipsw", eipsw, 32'h40);
            chk("R2", "psw after mask", psw, 32'h20);
        end
    endtask

    task automatic t_mask_blocked();
        logic [31:0] states [3] = '{32'h20, 32'h80, 32'h00};
        for (int k = 0; k < 3; k++) begin
            write_psw(states[k]);
            mi_req = 6'h3F; cur_pc = 32'h4800;
            if (k == 2) accept = 0;
            tick();
            idle();
            accept = 1;
            chk("R7", "masked no take", {31'b0, take}, 32'h0);
            chk("R7", "eipc unchanged", eipc, 32'h4014);
        end
    endtask

    task automatic t_lowest();
        write_psw(32'h0);
        mi_req = 6'b101100; cur_pc = 32'h5000;
        tick();
        idle();
        chk("R6", "lowest of 2,3,5", take_pc, 32'hA0);
        write_psw(32'h0);
        mi_req = 6'b110000; cur_pc = 32'h5004;
        tick();
        idle();
        chk("R6", "lowest of 4,5", take_pc, 32'hC0);
    endtask

    task automatic t_nmi_over_mask();
        write_psw(32'h0);
        nmi_req = 1; mi_req = 6'h01; cur_pc = 32'h6000;
        tick();
        idle();
        chk("R8", "nmi wins", take_pc, 32'h10);
        chk("R8", "eipc untouched", eipc, 32'h5004);
        chk("R8", "fepc", fepc, 32'h6000);
    endtask

    task automatic t_write_vs_entry();
        write_psw(32'h0);
        psw_we = 1; psw_wdata = 32'h5; mi_req = 6'h02; cur_pc = 32'h6100;
        tick();
        idle();
        chk("R10", "entry overrides write", psw, 32'h20);
        chk("R10", "entry taken", take_pc, 32'h90);
    endtask

    task automatic t_reset_req();
        write_psw(32'h80);
        nmi_req = 1;
        tick();
        idle();
        chk("R4", "pend before reset", {31'b0, nmi_pend}, 32'h1);
        rst_req = 1; nmi_req = 1; mi_req = 6'h3F; cur_pc = 32'h7000;
        tick();
        idle();
        chk("R1", "reset take", {31'b0, take}, 32'h1);
        chk("R8", "reset wins pc", take_pc, 32'h0);
        chk("R1", "reset psw", psw, 32'h20);
        chk("R1", "reset ecr", ecr, 32'h0);
        chk("R1", "reset pend", {31'b0, nmi_pend}, 32'h0);
        chk("R8", "fepc untouched", fepc, 32'h6000);
    endtask

    initial begin
        idle();
        accept = 1; cur_pc = '0; psw_wdata = '0;
        rst_n = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset_state();
        t_psw_write();
        t_nmi_entry();
        t_nmi_pending();
        t_mask_each();
        t_mask_blocked();
        t_lowest();
        t_nmi_over_mask();
        t_write_vs_entry();
        t_reset_req();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule